// File: doc/BRIEF.md
# EEPROM Word-Read Engine

This block fetches one 16-bit word from a serial EEPROM through a single host register. The host writes a word address with the start bit set. The engine then runs a complete SPI read frame on its own: it asserts chip select, sends the read opcode and the byte address, and clocks in two data bytes. It packs the two bytes into a word, places the word in the upper half of the register and raises a done flag. The host polls that flag and then takes the result.

The SPI pins can also be owned by a separate direct-access path, which is handled by an arbiter outside this block. The two share the pins through an interlock. The engine holds a pending start for as long as the arbiter's grant is high. While a frame is running, the engine drives a busy signal so that the arbiter will not grant during the frame.

Top module: `eeprom_word_reader`

## Requirements
- R1: After reset, `reg_rdata` reads 0, `spi_cs_n` is 1, `spi_sck` is 0 and `engine_busy` is 0.
- R2: A write with bit 0 of `reg_wdata` set latches `reg_wdata[15:2]` as the word address and starts a read. From the next cycle until the read completes, bit 0 of `reg_rdata` reads 1, and bits 15:2 read back the latched address. A write with bit 0 clear changes nothing.
- R3: An accepted start clears done (`reg_rdata[1]`) in the next cycle. Done becomes 1 only after the frame has ended, and at that point `reg_rdata[31:16]` holds the fetched word.
- R4: Each frame holds chip select low throughout and spans exactly 40 rising SCK edges. MOSI carries opcode 0x03 and then the 16-bit byte address (word address times two), both MSB first. The last 16 edges clock in the data.
- R5: Data bits are taken MSB first. The byte read from the even byte address becomes bits 23:16 of `reg_rdata`, and the byte that follows becomes bits 31:24.
- R6: SPI mode 0 applies. SCK is low whenever chip select is high. MOSI changes only while SCK is low. MISO is sampled on the rising edge of SCK.
- R7: Each SCK phase (high or low) lasts exactly `SCK_HALF` system clock cycles.
- R8: A start accepted while `direct_grant` is 1 is held pending: chip select stays high and `engine_busy` stays 0 until the grant drops, and then the frame runs. `engine_busy` is 1 for the whole time chip select is low.
- R9: A start written while a read is pending or running is ignored. The address and the eventual result belong to the first request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the read register |
| reg_wdata | input | 32 | Write data: bit 0 start, bits 15:2 word address |
| reg_rdata | output | 32 | bit 0 running, bit 1 done, bits 15:2 address, bits 31:16 word |
| direct_grant | input | 1 | Arbiter has given the SPI pins to direct access |
| engine_busy | output | 1 | Engine owns the SPI pins (frame in progress) |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the EEPROM |
| spi_miso | input | 1 | Serial data from the EEPROM |

## Verification
The hardest cases to reach from the ports are the interlock and a second start that arrives mid-frame. In both, nothing visible happens at the moment of the stimulus.

To cover the interlock, the bench raises `direct_grant`, writes a start and waits many cycles. It checks that chip select has stayed high and that busy has stayed low. It then drops the grant and checks the returned word.

To cover the mid-frame start, the bench writes a different address while chip select is low. It then confirms that both the captured address and the returned word belong to the first request.

A behavioural EEPROM model in the bench decodes the frame and returns address-dependent bytes. This exposes byte-order and address-doubling errors.

// File: rtl/ewr_pkg.sv
package ewr_pkg;
    localparam int WADDR_W    = 14;
    localparam int BADDR_W    = 16;
    localparam int FRAME_BITS = 8 + BADDR_W + 16;
    localparam int BCNT_W     = $clog2(FRAME_BITS);
    localparam logic [7:0] RD_OPCODE = 8'h03;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_TAIL
    } core_st_e;
endpackage

// File: rtl/ewr_clkdiv.sv
module ewr_clkdiv #(
    parameter int SCK_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(SCK_HALF - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!en || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ewr_spi_core.sv
module ewr_spi_core
    import ewr_pkg::*;
#(
    parameter int SCK_HALF = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic [BADDR_W-1:0] byte_addr,
    input  logic               miso,
    output logic               sck,
    output logic               cs_n,
    output logic               mosi,
    output logic               busy,
    output logic               done,
    output logic [15:0]        word
);
    localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(FRAME_BITS - 1);

    typedef struct packed {
        core_st_e              st;
        logic                  sck;
        logic [FRAME_BITS-1:0] tx;
        logic [15:0]           rx;
        logic [BCNT_W-1:0]     bitcnt;
        logic                  done;
    } core_s;

    core_s s_d, s_q;
    logic  tick;

    ewr_clkdiv #(.SCK_HALF(SCK_HALF)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (s_q.st != ST_IDLE),
        .tick (tick)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (launch) begin
                    s_d.st     = ST_SHIFT;
                    s_d.tx     = {RD_OPCODE, byte_addr, 16'h0000};
                    s_d.bitcnt = '0;
                    s_d.sck    = 1'b0;
                    s_d.rx     = '0;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!s_q.sck) begin
                        s_d.sck = 1'b1;
                        s_d.rx  = {s_q.rx[14:0], miso};
                    end else begin
                        s_d.sck = 1'b0;
                        s_d.tx  = {s_q.tx[FRAME_BITS-2:0], 1'b0};
                        if (s_q.bitcnt == LAST_BIT) begin
                            s_d.st = ST_TAIL;
                        end else begin
                            s_d.bitcnt = s_q.bitcnt + 1'b1;
                        end
                    end
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, sck: 1'b0, tx: '0, rx: '0, bitcnt: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign sck  = s_q.sck;
    assign cs_n = (s_q.st == ST_IDLE);
    assign mosi = s_q.tx[FRAME_BITS-1];
    assign busy = (s_q.st != ST_IDLE);
    assign done = s_q.done;
    assign word = {s_q.rx[7:0], s_q.rx[15:8]};
endmodule

// File: rtl/ewr_regs.sv
module ewr_regs
    import ewr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_start,
    input  logic [WADDR_W-1:0] wr_addr,
    input  logic               direct_grant,
    input  logic               core_busy,
    input  logic               core_done,
    input  logic [15:0]        core_word,
    output logic               launch,
    output logic [BADDR_W-1:0] byte_addr,
    output logic [31:0]        rdata
);
    typedef struct packed {
        logic [WADDR_W-1:0] addr;
        logic [15:0]        data;
        logic               done;
        logic               pend;
    } regs_s;

    regs_s r_d, r_q;

    always_comb begin
        r_d    = r_q;
        launch = r_q.pend && !direct_grant && !core_busy;
        if (launch) begin
            r_d.pend = 1'b0;
        end
        if (core_done) begin
            r_d.data = core_word;
            r_d.done = 1'b1;
        end
        if (wr_start && !r_q.pend && !core_busy) begin
            r_d.addr = wr_addr;
            r_d.done = 1'b0;
            r_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign byte_addr = BADDR_W'({r_q.addr, 1'b0});
    assign rdata     = {r_q.data, r_q.addr, r_q.done, r_q.pend | core_busy};
endmodule

// File: rtl/eeprom_word_reader.sv
module eeprom_word_reader
    import ewr_pkg::*;
#(
    parameter int SCK_HALF = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        direct_grant,
    output logic        engine_busy,
    output logic        spi_sck,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    logic               launch;
    logic [BADDR_W-1:0] byte_addr;
    logic               core_done;
    logic [15:0]        core_word;
    logic               unused_wbits;

    assign unused_wbits = ^{reg_wdata[31:16], reg_wdata[1]};

    ewr_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_start    (reg_wr && reg_wdata[0]),
        .wr_addr     (reg_wdata[WADDR_W+1:2]),
        .direct_grant(direct_grant),
        .core_busy   (engine_busy),
        .core_done   (core_done),
        .core_word   (core_word),
        .launch      (launch),
        .byte_addr   (byte_addr),
        .rdata       (reg_rdata)
    );

    ewr_spi_core #(.SCK_HALF(SCK_HALF)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .byte_addr(byte_addr),
        .miso     (spi_miso),
        .sck      (spi_sck),
        .cs_n     (spi_cs_n),
        .mosi     (spi_mosi),
        .busy     (engine_busy),
        .done     (core_done),
        .word     (core_word)
    );
endmodule

// File: rtl/ewr_checker.sv
module ewr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        direct_grant,
    input logic        engine_busy,
    input logic        spi_sck,
    input logic        spi_cs_n,
    input logic        spi_mosi
);
    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck); // R6

    AST_MOSI_HELD_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi)); // R6

    AST_NO_LAUNCH_UNDER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(engine_busy) |-> !$past(direct_grant)); // R8

    AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[0] && !reg_rdata[0]) |=> (!reg_rdata[1] && reg_rdata[0])); // R3

    AST_DONE_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[1]) |-> spi_cs_n); // R3

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[0] && reg_rdata[0]) |=> $stable(reg_rdata[15:2])); // R9
endmodule

bind eeprom_word_reader ewr_checker u_chk (.*);

// File: tb/eeprom_word_reader_bench.sv
module eeprom_word_reader_bench;
    localparam int SCK_HALF = 2;
    localparam int NVEC = 6;
    localparam logic [13:0] VADDR [NVEC] = '{14'h0000, 14'h0001, 14'h0155,
                                             14'h1FFF, 14'h2AAA, 14'h3FFF};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        direct_grant = 1'b0;
    logic        engine_busy;
    logic        spi_sck, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    eeprom_word_reader #(.SCK_HALF(SCK_HALF)) u_eeprom_word_reader (.*);

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return 8'(a[7:0] * 8'd29 + a[15:8] + 8'h5B);
    endfunction

    function automatic logic [15:0] exp_word(input logic [13:0] w);
        logic [15:0] b;
        b = {1'b0, w, 1'b0};
        return {mem_byte(b + 16'd1), mem_byte(b)};
    endfunction

    // EEPROM model, mode 0
    int          rises = 0;
    logic [23:0] cmd = '0;
    logic [15:0] stream = '0;
    time         last_rise = 0;
    time         rise_gap = 0;
    int          mode_viol = 0;

    always @(negedge spi_cs_n or posedge spi_sck) begin
        if (!spi_sck) begin
            rises = 0;
            cmd   = '0;
        end else if (!spi_cs_n) begin
            if (rises < 24) cmd = {cmd[22:0], spi_mosi};
            rises = rises + 1;
            if (rises == 24) stream = {mem_byte(cmd[15:0]), mem_byte(cmd[15:0] + 16'd1)};
            if (last_rise != 0) rise_gap = $time - last_rise;
            last_rise = $time;
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n && rises >= 24 && rises < 40) spi_miso = stream[15 - (rises - 24)];
    end

    always @(spi_mosi) if (spi_sck) mode_viol = mode_viol + 1;
    always @(posedge spi_sck) if (spi_cs_n) mode_viol = mode_viol + 1;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [31:0] v);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (reg_rdata[1]) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        bit ok;
        logic [31:0] snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(reg_rdata == 32'h0, "R1 rdata", reg_rdata, 32'h0);
        check(spi_cs_n && !spi_sck && !engine_busy, "R1 pins",
              {29'h0, spi_cs_n, spi_sck, engine_busy}, 32'h4);

        // Vector table: R2 R3 R4 R5 R7
        foreach (VADDR[k]) begin
            host_write({16'h0, VADDR[k], 2'b01});
            check(reg_rdata[1:0] == 2'b01, "R2/R3 start state", reg_rdata[1:0], 2'b01);
            wait_done(ok);
            check(ok && reg_rdata[31:16] == exp_word(VADDR[k]), "R5 word",
                  reg_rdata[31:16], exp_word(VADDR[k]));
            check(cmd == {8'h03, 1'b0, VADDR[k], 1'b0}, "R4 frame header",
                  cmd, {8'h03, 1'b0, VADDR[k], 1'b0});
            check(rises == 40, "R4 edge count", rises, 40);
            check(reg_rdata[15:2] == VADDR[k] && spi_cs_n, "R2 address readback",
                  reg_rdata[15:2], VADDR[k]);
            check(rise_gap == 2 * SCK_HALF * 10, "R7 sck period", 32'(rise_gap), 2 * SCK_HALF * 10);
        end
        check(mode_viol == 0, "R6 mode 0", mode_viol, 0);

        // R2: write with bit 0 clear ignored
        snap = reg_rdata;
        host_write(32'hFFFF_0F0E);
        repeat (20) @(negedge clk);
        check(reg_rdata == snap && spi_cs_n, "R2 no-start write", reg_rdata, snap);

        // R8: hold-off under grant
        direct_grant = 1'b1;
        host_write({16'h0, 14'h0123, 2'b01});
        repeat (60) @(negedge clk);
        check(spi_cs_n && !engine_busy && reg_rdata[1:0] == 2'b01, "R8 held off",
              {spi_cs_n, engine_busy, reg_rdata[1:0]}, 4'b1001);
        direct_grant = 1'b0;
        repeat (3) @(negedge clk);
        check(!spi_cs_n && engine_busy, "R8 busy with cs", {spi_cs_n, engine_busy}, 2'b01);
        wait_done(ok);
        check(ok && reg_rdata[31:16] == exp_word(14'h0123), "R8 result",
              reg_rdata[31:16], exp_word(14'h0123));

        // R9: second start mid-frame ignored
        host_write({16'h0, 14'h0042, 2'b01});
        repeat (30) @(negedge clk);
        host_write({16'h0, 14'h3ABC, 2'b01});
        check(reg_rdata[15:2] == 14'h0042, "R9 address kept", reg_rdata[15:2], 14'h0042);
        wait_done(ok);
        check(ok && reg_rdata[31:16] == exp_word(14'h0042), "R9 result",
              reg_rdata[31:16], exp_word(14'h0042));
        check(cmd[15:0] == 16'h0084, "R9 frame address", cmd[15:0], 16'h0084);
        repeat (20) @(negedge clk);
        check(spi_cs_n && reg_rdata[1], "R9 no second frame", {spi_cs_n, reg_rdata[1]}, 2'b11);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule